// File: doc/BRIEF.md
# SDRAM Maintenance Command Sequencer

This block drives the housekeeping side of an SDRAM controller. A write to the control register carries four one-shot trigger bits. The bits request a power-up sequence, entry to self-refresh, an immediate auto-refresh or an immediate precharge of all banks. The block turns these requests into a stream of SDRAM command codes on a 3-bit output. Between commands it inserts a fixed number of NOP cycles, so the device timing between commands is always met.

The data path sends its access requests through the block and receives a grant signal back. The grant is held low while any maintenance work is pending or running. It is also held low while a power-up sequence is armed but has not run, and while the device is in self-refresh. Power-up does not run when the trigger is written. It runs when the next access arrives, and that access is stalled until the sequence ends. Self-refresh entry waits until the data path reports that no transfer is active. Any later access brings the device out of self-refresh before it is granted.

A free-running interval counter issues periodic refreshes unless a level control disables them. Every auto-refresh that the block issues, from any source, restarts that counter. A precharge is never issued sooner than the programmed write-recovery delay after the data path reports the last write beat.

Top module: `sdr_maint_seq`

## Requirements
- R1: After reset, `sdr_cmd` is NOP (code 0). No command other than NOP appears until a trigger is written or a refresh interval expires.
- R2: The command codes are NOP=0, PRECHARGE ALL=1, AUTO REFRESH=2, LOAD MODE=3, SELF REFRESH ENTRY=4 and SELF REFRESH EXIT=5. No other code appears. Two non-NOP commands in one sequence are exactly GAP_CYC+1 (default 3) cycles apart.
- R3: Writing 1 to `cfg_pwrup` only arms power-up and issues no command. The next `acc_req` is stalled. The block then issues PRECHARGE ALL, AUTO REFRESH, AUTO REFRESH, LOAD MODE, and grants the access after that. Writing 0 to the bit has no effect.
- R4: When the block is idle, writing 1 to `cfg_force_pre` puts PRECHARGE ALL on `sdr_cmd` two cycles after the edge that samples the write. Writing 0 has no effect.
- R5: Writing 1 to `cfg_force_ref` issues PRECHARGE ALL two cycles after the sampling edge. It then issues AUTO REFRESH GAP_CYC+1 cycles after that.
- R6: With `cfg_ref_off`=0, the block runs a precharge and auto-refresh pair each time the refresh interval expires. With `cfg_ref_off`=1, an expiry issues nothing.
- R7: Any issued AUTO REFRESH restarts the interval. When idle, the next periodic AUTO REFRESH comes exactly `ref_period`+5 cycles after the previous AUTO REFRESH.
- R8: Writing 1 to `cfg_selfref` stalls accesses. While `xfer_busy` is high, no command is issued. After `xfer_busy` falls, the block issues PRECHARGE ALL and then SELF REFRESH ENTRY, and it then stays silent.
- R9: In self-refresh, an `acc_req` is not granted until SELF REFRESH EXIT has been issued.
- R10: A PRECHARGE ALL is issued no earlier than D+1 edges after the edge that samples `wr_done`. D is `cfg_twr`, taken as 1..3, and the value 0 is treated as 1. If the write and the force-precharge trigger are sampled on the same edge, the spacing is exactly D+1.
- R11: A trigger written while a sequence is running is kept pending. It is issued after the running sequence ends.
- R12: `acc_grant` is high only when `acc_req` is high and the block is idle with no pending work. While it is high, `sdr_cmd` is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_pwrup | input | 1 | Trigger: arm power-up sequence |
| cfg_selfref | input | 1 | Trigger: request self-refresh entry |
| cfg_force_ref | input | 1 | Trigger: immediate auto-refresh |
| cfg_force_pre | input | 1 | Trigger: immediate precharge all |
| cfg_ref_off | input | 1 | Level: suppress periodic refresh |
| cfg_twr | input | 2 | Write-to-precharge delay in cycles |
| ref_period | input | REF_W | Refresh interval in cycles |
| acc_req | input | 1 | Access request from the data path |
| xfer_busy | input | 1 | A data transfer is in flight |
| wr_done | input | 1 | Pulse on the final write data beat |
| sdr_cmd | output | 3 | SDRAM command code |
| acc_grant | output | 1 | Access may proceed |

## Verification
Each trigger is sampled on one edge. Starting the sequence takes one more edge, and the first command is registered on the edge after that. So a forced command is due on the second edge after the write, and each later command is due GAP_CYC+1 edges after the one before it. A monitor stamps every non-NOP command with its edge index. The checks compare those stamps with the write edge plus these fixed offsets: D+1 for the write-recovery cases, and `ref_period`+5 for the refresh-restart case. For stalls, the checks read `acc_grant` one nanosecond after driving `acc_req`, because the grant is combinational from registered state.

// File: rtl/sdr_maint_pkg.sv
package sdr_maint_pkg;

    typedef enum logic [2:0] {
        CMD_NOP       = 3'd0,
        CMD_PRE_ALL   = 3'd1,
        CMD_AUTO_REF  = 3'd2,
        CMD_LOAD_MODE = 3'd3,
        CMD_SR_ENTER  = 3'd4,
        CMD_SR_EXIT   = 3'd5
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        OP_PWRUP     = 3'd0,
        OP_REFRESH   = 3'd1,
        OP_PRECHARGE = 3'd2,
        OP_SR_ENTER  = 3'd3,
        OP_SR_EXIT   = 3'd4
    } maint_op_e;

    // number of commands in each maintenance sequence
    function automatic logic [2:0] op_len(input maint_op_e op);
        case (op)
            OP_PWRUP:     op_len = 3'd4;
            OP_REFRESH:   op_len = 3'd2;
            OP_PRECHARGE: op_len = 3'd1;
            OP_SR_ENTER:  op_len = 3'd2;
            OP_SR_EXIT:   op_len = 3'd1;
            default:      op_len = 3'd0;
        endcase
    endfunction

    // command issued at a given step of a sequence
    function automatic sdr_cmd_e op_step_cmd(input maint_op_e op, input logic [2:0] step);
        op_step_cmd = CMD_NOP;
        case (op)
            OP_PWRUP: begin
                case (step)
                    3'd0:    op_step_cmd = CMD_PRE_ALL;
                    3'd1:    op_step_cmd = CMD_AUTO_REF;
                    3'd2:    op_step_cmd = CMD_AUTO_REF;
                    3'd3:    op_step_cmd = CMD_LOAD_MODE;
                    default: op_step_cmd = CMD_NOP;
                endcase
            end
            OP_REFRESH:   op_step_cmd = (step == 3'd0) ? CMD_PRE_ALL : CMD_AUTO_REF;
            OP_PRECHARGE: op_step_cmd = CMD_PRE_ALL;
            OP_SR_ENTER:  op_step_cmd = (step == 3'd0) ? CMD_PRE_ALL : CMD_SR_ENTER;
            OP_SR_EXIT:   op_step_cmd = CMD_SR_EXIT;
            default:      op_step_cmd = CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] period,
    input  logic             reload,
    output logic             tick
);

    typedef struct packed {
        logic [REF_W-1:0] cnt;
    } tmr_s;

    tmr_s st_d, st_q;
    logic [REF_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + {{REF_W{1'b0}}, 1'b1};
        tick    = (cnt_inc >= {1'b0, period});
        if (reload || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_inc[REF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // the interval count restarts on every reload
    assert_reload_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q.cnt == '0));

endmodule

// File: rtl/sdr_twr_guard.sv
module sdr_twr_guard #(
    parameter int TWR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_done,
    input  logic [TWR_W-1:0] twr_cfg,
    output logic             pre_ok
);

    typedef struct packed {
        logic [TWR_W-1:0] cnt;
    } grd_s;

    grd_s st_d, st_q;
    logic [TWR_W-1:0] twr_eff;

    always_comb begin
        st_d    = st_q;
        twr_eff = (twr_cfg == '0) ? TWR_W'(1) : twr_cfg;
        if (wr_done) begin
            st_d.cnt = twr_eff;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        pre_ok = (st_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a write beat always closes the precharge window on the next cycle
    assert_wr_blocks_pre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !pre_ok);

endmodule

// File: rtl/sdr_maint_fsm.sv
module sdr_maint_fsm
    import sdr_maint_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_wr,
    input  logic     cfg_pwrup,
    input  logic     cfg_selfref,
    input  logic     cfg_force_ref,
    input  logic     cfg_force_pre,
    input  logic     ref_off,
    input  logic     ref_tick,
    input  logic     acc_req,
    input  logic     xfer_busy,
    input  logic     pre_ok,
    output sdr_cmd_e cmd,
    output logic     acc_grant,
    output logic     ref_reload
);

    localparam int GAP_W = (GAP_CYC < 1) ? 1 : $clog2(GAP_CYC + 1);

    typedef struct packed {
        logic             running;
        maint_op_e        op;
        logic [2:0]       step;
        logic [GAP_W-1:0] gap;
        sdr_cmd_e         cmd;
        logic             pwr_armed;
        logic             sr_req;
        logic             in_sr;
        logic             pend_ref;
        logic             pend_pre;
    } fsm_s;

    fsm_s     st_d, st_q;
    sdr_cmd_e step_cmd;
    logic     start;
    maint_op_e start_op;

    always_comb begin
        st_d       = st_q;
        st_d.cmd   = CMD_NOP;
        ref_reload = 1'b0;
        start      = 1'b0;
        start_op   = OP_PRECHARGE;
        step_cmd   = op_step_cmd(st_q.op, st_q.step);

        acc_grant = acc_req && !st_q.running && !st_q.in_sr && !st_q.pwr_armed
                    && !st_q.pend_ref && !st_q.pend_pre && !st_q.sr_req;

        if (!st_q.running) begin
            if (!xfer_busy) begin
                if (st_q.in_sr) begin
                    if (acc_req) begin
                        start    = 1'b1;
                        start_op = OP_SR_EXIT;
                    end
                end else if (st_q.pwr_armed && acc_req) begin
                    start          = 1'b1;
                    start_op       = OP_PWRUP;
                    st_d.pwr_armed = 1'b0;
                end else if (st_q.pend_pre) begin
                    start         = 1'b1;
                    start_op      = OP_PRECHARGE;
                    st_d.pend_pre = 1'b0;
                end else if (st_q.pend_ref) begin
                    start         = 1'b1;
                    start_op      = OP_REFRESH;
                    st_d.pend_ref = 1'b0;
                end else if (st_q.sr_req) begin
                    start       = 1'b1;
                    start_op    = OP_SR_ENTER;
                    st_d.sr_req = 1'b0;
                end
            end
            if (start) begin
                st_d.running = 1'b1;
                st_d.op      = start_op;
                st_d.step    = 3'd0;
                st_d.gap     = '0;
            end
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end else if (st_q.step == op_len(st_q.op)) begin
            st_d.running = 1'b0;
        end else if ((step_cmd != CMD_PRE_ALL) || pre_ok) begin
            st_d.cmd  = step_cmd;
            st_d.step = st_q.step + 3'd1;
            st_d.gap  = GAP_W'(GAP_CYC);
            if (step_cmd == CMD_AUTO_REF) ref_reload = 1'b1;
            if (step_cmd == CMD_SR_ENTER) st_d.in_sr = 1'b1;
            if (step_cmd == CMD_SR_EXIT)  st_d.in_sr = 1'b0;
        end

        // new requests are captured last so a same-cycle write is never lost
        if (ref_tick && !ref_off && !st_q.in_sr) st_d.pend_ref = 1'b1;
        if (cfg_wr) begin
            if (cfg_pwrup)     st_d.pwr_armed = 1'b1;
            if (cfg_selfref)   st_d.sr_req    = 1'b1;
            if (cfg_force_ref) st_d.pend_ref  = 1'b1;
            if (cfg_force_pre) st_d.pend_pre  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd = st_q.cmd;

    // every command is followed by at least one NOP
    assert_nop_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // only defined command codes leave the block
    assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd <= CMD_SR_EXIT));

    // the bus is quiet whenever an access is granted
    assert_grant_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |-> (cmd == CMD_NOP));

    // a granted access never coincides with a sequence start
    assert_grant_vs_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_grant |=> !st_q.running);

endmodule

// File: rtl/sdr_maint_seq.sv
module sdr_maint_seq
    import sdr_maint_pkg::*;
#(
    parameter int REF_W   = 16,
    parameter int GAP_CYC = 2,
    parameter int TWR_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_pwrup,
    input  logic             cfg_selfref,
    input  logic             cfg_force_ref,
    input  logic             cfg_force_pre,
    input  logic             cfg_ref_off,
    input  logic [TWR_W-1:0] cfg_twr,
    input  logic [REF_W-1:0] ref_period,
    input  logic             acc_req,
    input  logic             xfer_busy,
    input  logic             wr_done,
    output logic [2:0]       sdr_cmd,
    output logic             acc_grant
);

    logic     ref_tick;
    logic     ref_reload;
    logic     pre_ok;
    sdr_cmd_e cmd_w;

    sdr_refresh_timer #(.REF_W(REF_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (ref_period),
        .reload (ref_reload),
        .tick   (ref_tick)
    );

    sdr_twr_guard #(.TWR_W(TWR_W)) u_twr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_done (wr_done),
        .twr_cfg (cfg_twr),
        .pre_ok  (pre_ok)
    );

    sdr_maint_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr        (cfg_wr),
        .cfg_pwrup     (cfg_pwrup),
        .cfg_selfref   (cfg_selfref),
        .cfg_force_ref (cfg_force_ref),
        .cfg_force_pre (cfg_force_pre),
        .ref_off       (cfg_ref_off),
        .ref_tick      (ref_tick),
        .acc_req       (acc_req),
        .xfer_busy     (xfer_busy),
        .pre_ok        (pre_ok),
        .cmd           (cmd_w),
        .acc_grant     (acc_grant),
        .ref_reload    (ref_reload)
    );

    assign sdr_cmd = cmd_w;

    // ordering and write-recovery observers on the command port
    logic [3:0] since_wr_q;
    logic [2:0] last_cmd_q;
    logic [3:0] twr_need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_wr_q <= 4'hF;
            last_cmd_q <= CMD_NOP;
        end else begin
            if (wr_done)                since_wr_q <= 4'd0;
            else if (since_wr_q != 4'hF) since_wr_q <= since_wr_q + 4'd1;
            if (sdr_cmd != CMD_NOP)     last_cmd_q <= sdr_cmd;
        end
    end

    always_comb begin
        twr_need = (cfg_twr == '0) ? 4'd2 : (4'(cfg_twr) + 4'd1);
    end

    assert_twr_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_PRE_ALL) |-> (since_wr_q >= twr_need));

    assert_ref_after_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_AUTO_REF) |-> (last_cmd_q == CMD_PRE_ALL || last_cmd_q == CMD_AUTO_REF));

    assert_mode_after_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_LOAD_MODE) |-> (last_cmd_q == CMD_AUTO_REF));

    assert_sr_entry_after_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_SR_ENTER) |-> (last_cmd_q == CMD_PRE_ALL));

    assert_sr_exit_after_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sdr_cmd == CMD_SR_EXIT) |-> (last_cmd_q == CMD_SR_ENTER));

    assert_no_grant_in_sr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cmd_q == CMD_SR_ENTER) |-> !acc_grant);

endmodule

// File: tb/sdr_maint_seq_tb.sv
`timescale 1ns/1ps
module sdr_maint_seq_tb_top;

    localparam int REF_W = 16;
    localparam int P     = 30;
    localparam int TWR_VEC [4][2] = '{'{0, 2}, '{1, 2}, '{2, 3}, '{3, 4}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_pwrup = 1'b0;
    logic             cfg_selfref = 1'b0;
    logic             cfg_force_ref = 1'b0;
    logic             cfg_force_pre = 1'b0;
    logic             cfg_ref_off = 1'b1;
    logic [1:0]       cfg_twr = 2'd1;
    logic [REF_W-1:0] ref_period = REF_W'(P);
    logic             acc_req = 1'b0;
    logic             xfer_busy = 1'b0;
    logic             wr_done = 1'b0;
    logic [2:0]       sdr_cmd;
    logic             acc_grant;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int log_c [64];
    int log_t [64];
    int log_n    = 0;
    int base     = 0;

    always #4 clk = ~clk;

    sdr_maint_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pwrup(cfg_pwrup),
        .cfg_selfref(cfg_selfref), .cfg_force_ref(cfg_force_ref),
        .cfg_force_pre(cfg_force_pre), .cfg_ref_off(cfg_ref_off), .cfg_twr(cfg_twr),
        .ref_period(ref_period), .acc_req(acc_req), .xfer_busy(xfer_busy),
        .wr_done(wr_done), .sdr_cmd(sdr_cmd), .acc_grant(acc_grant)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (sdr_cmd != 3'd0 && log_n < 64) begin
            log_c[log_n] = int'(sdr_cmd);
            log_t[log_n] = cyc;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic mark();
        base = log_n;
    endtask

    function automatic int cnt();
        return log_n - base;
    endfunction

    task automatic write_cfg(input bit pw, input bit sr, input bit fr, input bit fp,
                             input bit wd, output int w);
        cfg_wr = 1'b1; cfg_pwrup = pw; cfg_selfref = sr;
        cfg_force_ref = fr; cfg_force_pre = fp; wr_done = wd;
        w = cyc + 1;
        step(1);
        cfg_wr = 1'b0; cfg_pwrup = 1'b0; cfg_selfref = 1'b0;
        cfg_force_ref = 1'b0; cfg_force_pre = 1'b0; wr_done = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int w;
        int got;
        int a_t;
        int f_t;
        step(3);
        rst_n = 1'b1;
        step(5);

        // R1: quiet after reset
        chk("R1 cmd after reset", int'(sdr_cmd), 0);
        chk("R1 no commands after reset", log_n, 0);
        acc_req = 1'b1; #1;
        chk("R12 grant when idle", int'(acc_grant), 1);
        acc_req = 1'b0;
        step(1);

        // R10 / R4: write-recovery table
        for (int i = 0; i < 4; i++) begin
            cfg_twr = 2'(TWR_VEC[i][0]);
            step(2);
            mark();
            write_cfg(0, 0, 0, 1, 1, w);
            step(12);
            chk("R4 one command per force", cnt(), 1);
            chk("R4 precharge code", log_c[base], 1);
            chk("R10 write-to-precharge spacing", log_t[base] - w, TWR_VEC[i][1]);
        end
        cfg_twr = 2'd1;

        // R4 / R3: zero writes have no effect
        mark();
        write_cfg(0, 0, 0, 0, 0, w);
        step(8);
        chk("R4 zero write issues nothing", cnt(), 0);
        acc_req = 1'b1; #1;
        chk("R3 zero write does not arm", int'(acc_grant), 1);
        acc_req = 1'b0;
        step(1);

        // R5 / R2: forced refresh
        mark();
        write_cfg(0, 0, 1, 0, 0, w);
        step(15);
        chk("R5 refresh command count", cnt(), 2);
        chk("R5 precharge first", log_c[base], 1);
        chk("R5 precharge timing", log_t[base] - w, 2);
        chk("R5 auto refresh second", log_c[base+1], 2);
        chk("R2 command spacing", log_t[base+1] - log_t[base], 3);

        // R3: power-up armed, runs on next access
        mark();
        write_cfg(1, 0, 0, 0, 0, w);
        step(10);
        chk("R3 arm issues nothing", cnt(), 0);
        acc_req = 1'b1; #1;
        chk("R3 first access stalled", int'(acc_grant), 0);
        got = 0;
        for (int k = 0; k < 60 && got == 0; k++) begin
            step(1);
            if (acc_grant) got = 1;
        end
        chk("R3 access granted after sequence", got, 1);
        chk("R3 power-up command count", cnt(), 4);
        chk("R3 step0 precharge", log_c[base], 1);
        chk("R3 step1 auto refresh", log_c[base+1], 2);
        chk("R3 step2 auto refresh", log_c[base+2], 2);
        chk("R3 step3 load mode", log_c[base+3], 3);
        chk("R2 power-up spacing a", log_t[base+1] - log_t[base], 3);
        chk("R2 power-up spacing b", log_t[base+3] - log_t[base+2], 3);
        acc_req = 1'b0;
        step(3);

        // R11: trigger during a running sequence is held
        mark();
        write_cfg(0, 0, 1, 0, 0, w);
        step(1);
        acc_req = 1'b1; #1;
        chk("R12 no grant while running", int'(acc_grant), 0);
        acc_req = 1'b0;
        write_cfg(0, 0, 0, 1, 0, got);
        step(15);
        chk("R11 command count", cnt(), 3);
        chk("R11 running sequence finishes", log_c[base+1], 2);
        chk("R11 pending precharge last", log_c[base+2], 1);
        chk("R11 pending issue time", log_t[base+2] - w, 10);

        // R8 / R9: self-refresh entry after drain, exit on access
        xfer_busy = 1'b1;
        mark();
        write_cfg(0, 1, 0, 0, 0, w);
        step(12);
        chk("R8 waits for transfer", cnt(), 0);
        acc_req = 1'b1; #1;
        chk("R8 access stalled by request", int'(acc_grant), 0);
        acc_req = 1'b0;
        xfer_busy = 1'b0;
        step(15);
        chk("R8 entry command count", cnt(), 2);
        chk("R8 precharge before entry", log_c[base], 1);
        chk("R8 entry command", log_c[base+1], 4);
        step(10);
        chk("R8 silent in self-refresh", cnt(), 2);
        acc_req = 1'b1; #1;
        chk("R9 stalled in self-refresh", int'(acc_grant), 0);
        got = 0;
        for (int k = 0; k < 40 && got == 0; k++) begin
            step(1);
            if (acc_grant) got = 1;
        end
        chk("R9 granted after exit", got, 1);
        chk("R9 exit command", log_c[base+2], 5);
        acc_req = 1'b0;
        step(3);

        // R6: disabled periodic refresh issues nothing
        mark();
        step(100);
        chk("R6 disabled refresh silent", cnt(), 0);

        // R6 / R7: periodic refresh and restart on forced refresh
        cfg_ref_off = 1'b0;
        mark();
        got = 0;
        for (int k = 0; k < 80 && got == 0; k++) begin
            step(1);
            if (cnt() >= 2) got = 1;
        end
        chk("R6 periodic refresh issued", got, 1);
        chk("R6 periodic refresh code", log_c[base+1], 2);
        a_t = log_t[base+1];
        step(5);
        mark();
        write_cfg(0, 0, 1, 0, 0, w);
        step(60);
        chk("R7 forced refresh code", log_c[base+1], 2);
        f_t = log_t[base+1];
        chk("R5 forced refresh timing", f_t - w, 5);
        chk("R7 next periodic code", log_c[base+3], 2);
        chk("R7 interval restarted", log_t[base+3] - f_t, P + 5);
        if (a_t >= f_t) chk("R7 order", a_t, f_t);
        cfg_ref_off = 1'b1;
        step(5);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule